// File: doc/BRIEF.md
# Two-Wire Register Read Slave

This block is the slave end of a two-wire serial bus (SCL clock, SDA data) that exposes a bank of byte registers for reading. The master first addresses the slave in write direction and sends one byte that sets an internal register pointer. It then issues a repeated START and addresses the slave again in read direction. The slave answers with the byte at the pointer. After each byte the master either acknowledges and receives the next register, or declines and closes with a STOP.

SCL and SDA arrive as raw levels and are oversampled on the system clock. SDA is driven through an open-drain enable: when `sda_oe` is 1 the line is pulled low. Register contents come from an external synchronous read port with one cycle of latency. A power-good input from a supply monitor gates the whole block. While it is low the slave is held in reset and takes no part on the bus. When it rises, the slave comes up in standby mode.

Top module: `i2c_regread_slave`

## Requirements
- R1: While `rst` is 1 or `pwr_good` is 0, the block holds `sda_oe`=0, `rd_en`=0 and `mode`=1, and it acknowledges nothing. One cycle after both are released, `mode` reads 0 (standby).
- R2: A START followed by address byte 0x88 (7-bit address 0x44, write) or 0x89 (read) is acknowledged: SDA is held low during the ninth SCL pulse.
- R3: An address byte other than 0x88 or 0x89 is not acknowledged. Every later byte is also ignored, without acknowledge, until the next START or STOP.
- R4: After 0x88, the next byte is acknowledged and its low `ADDR_W` bits (default 3) load the register pointer. For example, 0x0D selects register 5.
- R5: After a repeated START and 0x89, the slave sends the register at the pointer, MSB first, one bit per SCL pulse.
- R6: When the master acknowledges (SDA low on the ninth pulse), the slave sends the next register. The pointer advances by one after each sent byte and wraps from 2^ADDR_W-1 to 0.
- R7: After a master NACK (SDA high on the ninth pulse), the slave stops driving SDA until a new START. A STOP returns the slave to idle.
- R8: `sda_oe` changes only while SCL is low. The exceptions are a power-good drop and a START or STOP, which are recognized in any state.
- R9: If `pwr_good` falls during a transfer, `sda_oe` is 0 and `mode` is 1 on the next cycle. After power returns, the pointer restarts at register 0.
- R10: Each byte sent causes exactly one single-cycle `rd_en` pulse. The first pulse comes while the read address is being acknowledged, and each later one during the master's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good flag; 0 holds the block in reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| rd_en | output | 1 | Register bank read strobe |
| rd_addr | output | ADDR_W | Register bank read address |
| rd_data | input | 8 | Register bank data, valid one cycle after `rd_en` |
| mode | output | 1 | 1 = held in reset, 0 = standby |

## Verification
Two events can land in the same cycle: a supply-good drop and the slave actively pulling SDA low for a data bit. The bench sets the pointer so that the second byte of a burst starts with a 0 bit. It confirms that the slave is driving, then drops `pwr_good` while SCL is low. It then checks that the drive releases one cycle later and `mode` flips to 1. After power returns, a read without a pointer write must return register 0, which shows the abort also cleared the pointer. A second overlap is the register fetch on a master ACK coinciding with the pointer advance. It is judged across bursts that wrap past the last register.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } rd_state_e;

  typedef enum logic [1:0] {
    AK_WADDR,
    AK_RADDR,
    AK_PTR
  } ack_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic srst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (srst) begin
      scl_m <= 1'b1;
      sda_m <= 1'b1;
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= scl_in;
      sda_m <= sda_in;
      scl_s <= scl_m;
      sda_s <= sda_m;
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [3:0] FULL = 4'(BYTE_BITS);

  rd_state_e          st;
  ack_kind_e          kind;
  logic [3:0]         cnt;
  logic [7:0]         rx;
  logic [7:0]         tx;
  logic [ADDR_W-1:0]  ptr;
  logic               ld;
  logic               more;

  always_ff @(posedge clk) begin
    if (srst) begin
      st      <= ST_IDLE;
      kind    <= AK_WADDR;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      ptr     <= '0;
      ld      <= 1'b0;
      more    <= 1'b0;
      sda_oe  <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_en <= 1'b0;
      ld    <= rd_en;
      if (ld) tx <= rd_data;

      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_REG: begin
            if (scl_rise && cnt != FULL) begin
              rx  <= {rx[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == FULL) begin
              if (st == ST_REG) begin
                ptr    <= rx[ADDR_W-1:0];
                sda_oe <= 1'b1;
                kind   <= AK_PTR;
                st     <= ST_ACK;
              end else if (rx[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                if (rx[0]) begin
                  kind    <= AK_RADDR;
                  rd_en   <= 1'b1;
                  rd_addr <= ptr;
                end else begin
                  kind <= AK_WADDR;
                end
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              case (kind)
                AK_WADDR: begin sda_oe <= 1'b0;   st <= ST_REG;  end
                AK_RADDR: begin sda_oe <= ~tx[7]; st <= ST_TX;   end
                default:  begin sda_oe <= 1'b0;   st <= ST_SKIP; end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                st     <= ST_MACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              more <= ~sda_s;
              if (!sda_s) begin
                rd_en   <= 1'b1;
                rd_addr <= ptr;
              end
            end else if (scl_fall) begin
              cnt <= '0;
              if (more) begin
                sda_oe <= ~tx[7];
                st     <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regread_slave.sv
module i2c_regread_slave
#(
  parameter int unsigned ADDR_W   = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              mode
);
  logic srst;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  assign srst = rst | ~pwr_good;

  always_ff @(posedge clk) begin
    mode <= srst;
  end

  i2c_line_sync u_sync (
    .clk       (clk),
    .srst      (srst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rd_ctrl #(
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .srst      (srst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
  );
endmodule

// File: rtl/i2c_regread_slave_chk.sv
module i2c_regread_slave_chk (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic scl_s,
  input logic stop_det,
  input logic sda_oe,
  input logic rd_en,
  input logic mode
);
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!sda_oe && !rd_en && mode)); // R1

  AST_UP_STANDBY: assert property (@(posedge clk) disable iff (rst)
    pwr_good |=> !mode); // R1

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R7

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en); // R10
endmodule

bind i2c_regread_slave i2c_regread_slave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_good (pwr_good),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .rd_en    (rd_en),
  .mode     (mode)
);

// File: tb/i2c_regread_slave_bench.sv
module i2c_regread_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int AW         = 3;
  localparam logic [11:0] VEC [5] = '{12'h001, 12'h032, 12'h064, 12'h0D1, 12'h073};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, rd_en, mode;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic sda_line;
  int nchk = 0, nfail = 0, fetches = 0, oe_viol = 0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_regread_slave u_i2c_regread_slave (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode)
  );

  function automatic logic [7:0] bank(input int a);
    return 8'((a * 37 + 92) & 255);
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= bank(int'(rd_addr));
      fetches <= fetches + 1;
    end
  end

  // R8 monitor: drive changes with SCL high while powered
  always @(negedge clk) begin
    if (pwr_good && !rst && sda_oe !== oe_prev && m_scl && scl_prev) oe_viol++;
    oe_prev  = sda_oe;
    scl_prev = m_scl;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(2);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q - 1);
    ack = ~sda_line;
    tick(1); m_scl = 1'b0; tick(2);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q - 1);
      b[i] = sda_line;
      tick(1); m_scl = 1'b0;
    end
    tick(2);
    m_sda = mack ? 1'b0 : 1'b1;
    tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(2);
  endtask

  task automatic do_read(input logic [7:0] pb, input int n);
    logic a;
    logic [7:0] b;
    int f0;
    bus_start();
    wbyte(8'h88, a); check("R2", 8'(a), 8'd1);
    wbyte(pb, a);    check("R4", 8'(a), 8'd1);
    bus_start();
    f0 = fetches;
    wbyte(8'h89, a); check("R2", 8'(a), 8'd1);
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, b);
      check(k == 0 ? "R5" : "R6", b, bank((int'(pb) + k) % 8));
    end
    bus_stop();
    check("R10", 8'(fetches - f0), 8'(n));
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    // R1: reset state
    tick(4);
    check("R1", {5'b0, sda_oe, rd_en, mode}, 8'h01);
    rst = 1'b0;
    tick(3);
    check("R1", 8'(mode), 8'h00);
    // R1: supply low blocks the bus
    pwr_good = 1'b0;
    tick(2);
    check("R1", 8'(mode), 8'h01);
    bus_start();
    wbyte(8'h88, a); check("R1", 8'(a), 8'h00);
    bus_stop();
    pwr_good = 1'b1;
    tick(4);

    // vector table walk
    for (int v = 0; v < 5; v++) do_read(VEC[v][11:4], int'(VEC[v][3:0]));

    // R3: foreign address, then ignored until START/STOP
    bus_start();
    wbyte(8'h90, a); check("R3", 8'(a), 8'h00);
    wbyte(8'h88, a); check("R3", 8'(a), 8'h00);
    bus_stop();
    do_read(8'h02, 1);

    // R7: nothing driven after master NACK
    bus_start();
    wbyte(8'h88, a);
    wbyte(8'h01, a);
    bus_start();
    wbyte(8'h89, a);
    rbyte(1'b0, b); check("R5", b, bank(1));
    rbyte(1'b0, b); check("R7", b, 8'hFF);
    bus_stop();

    // R9: supply drop while slave pulls SDA low
    bus_start();
    wbyte(8'h88, a);
    wbyte(8'h05, a);
    bus_start();
    wbyte(8'h89, a);
    rbyte(1'b1, b); check("R6", b, bank(5));
    tick(Q);
    check("R9", 8'(sda_oe), 8'h01);
    pwr_good = 1'b0;
    tick(1);
    check("R9", {6'b0, sda_oe, mode}, 8'h01);
    tick(3);
    pwr_good = 1'b1;
    tick(2);
    bus_stop();
    bus_start();
    wbyte(8'h89, a); check("R9", 8'(a), 8'h01);
    rbyte(1'b0, b);  check("R9", b, bank(0));
    bus_stop();

    check("R8", 8'(oe_viol), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule